// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the cycle-exact timing of a successive-approximation converter. It runs on a clock at twice the converter clock rate, so each of its cycles is one half converter cycle, and it places the sample-and-hold strobe and the end of each conversion at whole or half converter-cycle points. It covers single-ended and differential inputs and three ways of starting a conversion: a user request, free running, and an external trigger.

A half-rate phase, derived inside the block while it is enabled, aligns differential conversions, which stretch by one converter cycle when that phase is high. The first conversion after the block is enabled is an extended one. A differential conversion started by the trigger is marked invalid unless the block was disabled and enabled again before it, because that is what forces an extended, valid conversion. The analog path and the bit decisions are not part of the block.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is held or `enable_i` is low, `busy_o`, `sample_o` and `done_o` are low; dropping `enable_i` during a conversion clears `busy_o` in the cycle after the drop.
- R2: The first conversion accepted after `enable_i` rises lasts 50 cycles (25 converter cycles), with `sample_o` in cycle 27 (13.5 converter cycles).
- R3: Any later single-ended conversion started by request lasts 26 cycles, with `sample_o` in cycle 3. Cycle 1 is the cycle after the edge that accepts the start.
- R4: The internal phase is low when `enable_i` rises and toggles every 2 cycles while enabled. A later differential conversion started by request lasts 26 cycles with `sample_o` in cycle 3 if the phase is low when it is accepted, and 28 cycles with `sample_o` in cycle 5 if it is high.
- R5: In free-running mode (`mode_i` = 1) the next conversion begins in the cycle after `done_o`, with `busy_o` held high. A chained differential conversion lasts 28 cycles with `sample_o` in cycle 5. A chained single-ended one lasts 26 with `sample_o` in cycle 3.
- R6: In trigger mode (`mode_i` = 2) only `trigger_i` starts a conversion, lasting 27 cycles with `sample_o` in cycle 4 (unless extended, R2). In modes 0, 1 and 3 (3 acts as 0) only `start_i` does.
- R7: `valid_o` changes only in the cycle after `done_o`. It goes low after a differential conversion started by trigger that was not extended, and high after any other conversion.
- R8: `done_o` is high for exactly one cycle, the last cycle of the conversion. `busy_o` is high from cycle 1 through that cycle. `sample_o` is high in exactly one cycle of each conversion.
- R9: A start or trigger that arrives while `busy_o` is high is ignored and does not change the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Converter enable |
| start_i | input | 1 | User start request |
| trigger_i | input | 1 | External trigger pulse |
| mode_i | input | 2 | 0 single, 1 free running, 2 triggered, 3 as single |
| diff_i | input | 1 | Selected channel is differential |
| sample_o | output | 1 | Sample-and-hold strobe, one cycle |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Completion pulse, one cycle |
| valid_o | output | 1 | Last completed result is valid |

## Verification
The bench builds the block with its default timing parameters, 6-bit counter and stretched chaining of differential free-running conversions. With these values every length (26, 27, 28, 50) and strobe point falls within the counter range. Both phase values come from shifting the idle gap before a start, and extended conversions come from disable and enable cycles placed at random. Start and trigger pulses in the middle of conversions exercise the rule that requests arriving while busy are dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_FREE   = 2'd1,
      MODE_AUTO   = 2'd2,
      MODE_SPARE  = 2'd3
   } conv_mode_e;

   localparam int unsigned MAX_CNT_W = 8;
endpackage

// File: rtl/adc_seq_phase.sv
module adc_seq_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic ck2_o
);
   logic sub_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         sub_q <= 1'b0;
         ck2_o <= 1'b0;
      end else begin
         sub_q <= ~sub_q;
         if (sub_q) ck2_o <= ~ck2_o;
      end
   end

   // R4
   ck2_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !ck2_o);
endmodule

// File: rtl/adc_seq_plan.sv
module adc_seq_plan
   import adc_seq_pkg::*;
#(
   parameter int unsigned CNT_W         = 6,
   parameter int unsigned NORM_HC       = 26,
   parameter int unsigned LONG_HC       = 28,
   parameter int unsigned EXT_HC        = 50,
   parameter int unsigned AUTO_HC       = 27,
   parameter int unsigned NORM_SMP      = 3,
   parameter int unsigned LONG_SMP      = 5,
   parameter int unsigned EXT_SMP       = 27,
   parameter int unsigned AUTO_SMP      = 4,
   parameter bit          FREE_DIFF_LONG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             start_i,
   input  logic             trigger_i,
   input  logic [1:0]       mode_i,
   input  logic             diff_i,
   input  logic             ck2_i,
   input  logic             busy_i,
   input  logic             done_i,
   output logic             launch_o,
   output logic [CNT_W-1:0] len_o,
   output logic [CNT_W-1:0] smp_o,
   output logic             ok_o
);
   localparam logic [CNT_W-1:0] L_NORM = CNT_W'(NORM_HC);
   localparam logic [CNT_W-1:0] L_LONG = CNT_W'(LONG_HC);
   localparam logic [CNT_W-1:0] L_EXT  = CNT_W'(EXT_HC);
   localparam logic [CNT_W-1:0] L_AUTO = CNT_W'(AUTO_HC);
   localparam logic [CNT_W-1:0] S_NORM = CNT_W'(NORM_SMP);
   localparam logic [CNT_W-1:0] S_LONG = CNT_W'(LONG_SMP);
   localparam logic [CNT_W-1:0] S_EXT  = CNT_W'(EXT_SMP);
   localparam logic [CNT_W-1:0] S_AUTO = CNT_W'(AUTO_SMP);

   logic ext_q, is_auto, is_free, req, chain, chain_long;

   assign is_auto  = (mode_i == MODE_AUTO);
   assign is_free  = (mode_i == MODE_FREE);
   assign req      = is_auto ? trigger_i : start_i;
   assign chain    = en_i && done_i && is_free;
   assign launch_o = (en_i && !busy_i && req) || chain;

   generate
      if (FREE_DIFF_LONG) begin : g_chain_long
         assign chain_long = diff_i;
      end else begin : g_chain_phase
         assign chain_long = diff_i && ck2_i;
      end
   endgenerate

   always_comb begin
      ok_o = 1'b1;
      if (ext_q) begin
         len_o = L_EXT;  smp_o = S_EXT;
      end else if (chain) begin
         len_o = chain_long ? L_LONG : L_NORM;
         smp_o = chain_long ? S_LONG : S_NORM;
      end else if (is_auto) begin
         len_o = L_AUTO; smp_o = S_AUTO;
         ok_o  = !diff_i;
      end else if (diff_i && ck2_i) begin
         len_o = L_LONG; smp_o = S_LONG;
      end else begin
         len_o = L_NORM; smp_o = S_NORM;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) ext_q <= 1'b1;
      else if (launch_o)   ext_q <= 1'b0;
   end

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && !done_i |-> !launch_o);
   // R2
   ext_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch_o && $past(!en_i) |-> len_o == L_EXT);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             launch_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic [CNT_W-1:0] smp_i,
   input  logic             ok_i,
   output logic             sample_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             valid_o
);
   logic [CNT_W-1:0] hcnt_q, len_q, smp_q;
   logic             ok_q;

   assign done_o   = busy_o && (hcnt_q == len_q);
   assign sample_o = busy_o && (hcnt_q == smp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         hcnt_q <= '0;
         len_q  <= '0;
         smp_q  <= '0;
         ok_q   <= 1'b0;
      end else if (!en_i) begin
         busy_o <= 1'b0;
         hcnt_q <= '0;
      end else if (launch_i) begin
         busy_o <= 1'b1;
         hcnt_q <= CNT_W'(1);
         len_q  <= len_i;
         smp_q  <= smp_i;
         ok_q   <= ok_i;
      end else if (busy_o) begin
         if (done_o) busy_o <= 1'b0;
         else        hcnt_q <= hcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      valid_o <= 1'b0;
      else if (done_o) valid_o <= ok_q;
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o && en_i |=> busy_o);
   // R1
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !busy_o && !done_o && !sample_o);
   // R7
   valid_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(valid_o) |-> $past(done_o));
   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sample_o, done_o}));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
   import adc_seq_pkg::*;
#(
   parameter int unsigned CNT_W          = 6,
   parameter int unsigned NORM_HC        = 26,
   parameter int unsigned LONG_HC        = 28,
   parameter int unsigned EXT_HC         = 50,
   parameter int unsigned AUTO_HC        = 27,
   parameter int unsigned NORM_SMP       = 3,
   parameter int unsigned LONG_SMP       = 5,
   parameter int unsigned EXT_SMP        = 27,
   parameter int unsigned AUTO_SMP       = 4,
   parameter bit          FREE_DIFF_LONG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable_i,
   input  logic       start_i,
   input  logic       trigger_i,
   input  logic [1:0] mode_i,
   input  logic       diff_i,
   output logic       sample_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       valid_o
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > MAX_CNT_W)
         $error("adc_seq_top: CNT_W out of range");
      if (EXT_HC > CNT_MAX || LONG_HC > CNT_MAX || NORM_HC > CNT_MAX || AUTO_HC > CNT_MAX)
         $error("adc_seq_top: a conversion length exceeds the counter");
      if (EXT_SMP >= EXT_HC || LONG_SMP >= LONG_HC || NORM_SMP >= NORM_HC || AUTO_SMP >= AUTO_HC)
         $error("adc_seq_top: a strobe point is not inside its conversion");
      if (EXT_SMP == 0 || LONG_SMP == 0 || NORM_SMP == 0 || AUTO_SMP == 0)
         $error("adc_seq_top: strobe points start at cycle 1");
   endgenerate

   logic             ck2, launch, ok;
   logic [CNT_W-1:0] len, smp;

   adc_seq_phase i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (enable_i),
      .ck2_o (ck2)
   );

   adc_seq_plan #(
      .CNT_W(CNT_W), .NORM_HC(NORM_HC), .LONG_HC(LONG_HC), .EXT_HC(EXT_HC),
      .AUTO_HC(AUTO_HC), .NORM_SMP(NORM_SMP), .LONG_SMP(LONG_SMP),
      .EXT_SMP(EXT_SMP), .AUTO_SMP(AUTO_SMP), .FREE_DIFF_LONG(FREE_DIFF_LONG)
   ) i_plan (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (enable_i),
      .start_i   (start_i),
      .trigger_i (trigger_i),
      .mode_i    (mode_i),
      .diff_i    (diff_i),
      .ck2_i     (ck2),
      .busy_i    (busy_o),
      .done_i    (done_o),
      .launch_o  (launch),
      .len_o     (len),
      .smp_o     (smp),
      .ok_o      (ok)
   );

   adc_seq_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (enable_i),
      .launch_i (launch),
      .len_i    (len),
      .smp_i    (smp),
      .ok_i     (ok),
      .sample_o (sample_o),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .valid_o  (valid_o)
   );
endmodule

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;
   logic       clk = 1'b0;
   logic       rst_n, enable, start, trig, diff;
   logic [1:0] mode;
   logic       sample, busy, done, valid;

   int tests = 0, fails = 0, cyc = 0;
   int unsigned n_en = 0;
   bit ext = 1'b1;

   always #10 clk = ~clk;

   adc_seq_top i_adc_seq_top (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .start_i(start),
      .trigger_i(trig), .mode_i(mode), .diff_i(diff),
      .sample_o(sample), .busy_o(busy), .done_o(done), .valid_o(valid)
   );

   always @(posedge clk) begin
      if (!enable || !rst_n) n_en <= 0;
      else n_en <= n_en + 1;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(bit e, int m, bit d, bit ph, bit chained);
      if (e) return 50;
      if (chained) return d ? 28 : 26;
      if (m == 2) return 27;
      if (d && ph) return 28;
      return 26;
   endfunction

   function automatic int exp_smp(bit e, int m, bit d, bit ph, bit chained);
      if (e) return 27;
      if (chained) return d ? 5 : 3;
      if (m == 2) return 4;
      if (d && ph) return 5;
      return 3;
   endfunction

   function automatic int exp_ok(bit e, int m, bit d);
      return (m == 2 && d && !e) ? 0 : 1;
   endfunction

   // Measure one conversion; cycle 1 is the next negedge.
   task automatic measure(input int elen, input int esmp, input bit noise,
                          input int pvalid, input bit stop_free, input string tag);
      int s_at = -1, d_at = -1, s_cnt = 0;
      bit low_busy = 0;
      for (int k = 1; k <= 70; k++) begin
         @(negedge clk);
         start = 0; trig = 0;
         if (k == 1 && stop_free) mode = 2'd0;
         if (k == 1 && pvalid >= 0) chk(valid == pvalid[0], "R7 valid after prior done", valid, pvalid);
         if (noise && k == 4) begin start = 1; trig = 1; end
         if (!busy) low_busy = 1;
         if (sample) begin s_cnt++; if (s_at < 0) s_at = k; end
         if (done) begin d_at = k; break; end
      end
      chk(d_at == elen, {tag, " length"}, d_at, elen);
      chk(s_at == esmp && s_cnt == 1, {tag, " sample point"}, s_at, esmp);
      chk(!low_busy, "R8 busy held through conversion", low_busy, 0);
      if (noise) chk(d_at == elen, "R9 request while busy ignored", d_at, elen);
   endtask

   task automatic post(input bit ebusy, input int evalid, input string tag);
      @(negedge clk);
      chk(busy == ebusy, {tag, " busy after done"}, busy, ebusy);
      chk(valid == evalid[0], "R7 valid after done", valid, evalid);
   endtask

   task automatic go(input int m, input bit d, output bit ph);
      mode = m[1:0]; diff = d;
      ph = n_en[1];
      if (m == 2) trig = 1; else start = 1;
   endtask

   task automatic toggle_enable();
      @(negedge clk); enable = 0;
      repeat (2) @(negedge clk);
      enable = 1; ext = 1;
   endtask

   task automatic wait_phase(input bit want);
      @(negedge clk);
      while (n_en[1] != want) @(negedge clk);
   endtask

   task automatic one(input int m, input bit d, input bit noise, input string tag);
      bit ph, e;
      int l, s, o;
      e = ext;
      go(m, d, ph);
      l = exp_len(e, m, d, ph, 0); s = exp_smp(e, m, d, ph, 0); o = exp_ok(e, m, d);
      ext = 0;
      if (m == 1) begin
         measure(l, s, noise, -1, 0, tag);
         measure(exp_len(0, 1, d, 0, 1), exp_smp(0, 1, d, 0, 1), 0, o, 1, "R5 chained");
         post(0, 1, "R5");
      end else begin
         measure(l, s, noise, -1, 0, tag);
         post(0, o, tag);
      end
   endtask

   initial begin
      bit ph;
      int seed_val;
      seed_val = $urandom(32'h5eed_adc0);
      rst_n = 0; enable = 0; start = 0; trig = 0; diff = 0; mode = 0;
      repeat (3) @(negedge clk);
      chk(!busy && !sample && !done && !valid, "R1 reset state", {busy, sample, done, valid}, 0);
      rst_n = 1;
      @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
      chk(!busy, "R1 disabled ignores start", busy, 0);
      enable = 1; ext = 1;
      repeat (2) @(negedge clk);

      one(0, 0, 0, "R2 extended first");
      one(0, 0, 1, "R3 single-ended");
      wait_phase(0);
      one(0, 1, 0, "R4 diff phase low");
      wait_phase(1);
      one(0, 1, 1, "R4 diff phase high");
      one(2, 0, 0, "R6 triggered");
      one(2, 1, 1, "R6 triggered diff");
      toggle_enable();
      one(2, 1, 0, "R2 re-enabled trigger");

      // R6: start ignored in trigger mode, trigger ignored in single mode
      begin
         bit seen = 0;
         @(negedge clk); mode = 2; start = 1;
         for (int k = 0; k < 8; k++) begin @(negedge clk); start = 0; if (busy) seen = 1; end
         chk(!seen, "R6 start ignored in trigger mode", seen, 0);
         seen = 0;
         mode = 0; trig = 1;
         for (int k = 0; k < 8; k++) begin @(negedge clk); trig = 0; if (busy) seen = 1; end
         chk(!seen, "R6 trigger ignored in single mode", seen, 0);
      end

      one(1, 1, 0, "R5 free diff first");
      one(1, 0, 1, "R5 free single-ended first");

      // R1: abort by disable
      @(negedge clk); mode = 0; diff = 0; start = 1;
      repeat (5) @(negedge clk);
      start = 0;
      chk(busy, "R1 busy before abort", busy, 1);
      enable = 0;
      @(negedge clk);
      chk(!busy && !done, "R1 abort clears busy", busy, 0);
      enable = 1; ext = 1;
      repeat (2) @(negedge clk);

      for (int it = 0; it < 40; it++) begin
         int m, gap;
         bit d, nz;
         gap = $urandom_range(0, 3);
         repeat (gap) @(negedge clk);
         if ($urandom_range(0, 7) == 0) toggle_enable();
         m = $urandom_range(0, 3);
         d = $urandom_range(0, 1) != 0;
         nz = $urandom_range(0, 1) != 0;
         @(negedge clk);
         one(m, d, nz, "R3 R4 R6 random");
      end
      ph = 0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule